// File: doc/BRIEF.md
# Pause Quanta Countdown Timer

This block turns received pause events into a transmit-hold signal. The receive-side frame parser passes each accepted pause frame in as a one-cycle event that carries its 16-bit quanta value. A non-zero value is a pause request (XOFF). A zero value is a resume (XON). The block holds the quanta in a down-counter and decrements it once per slot time. A slot time is 64 byte times. The block derives it from a byte-time tick that the MAC datapath supplies. While the count is non-zero, `tx_paused` is high, and the local transmitter must not start a new frame.

A response-enable input supports asymmetric flow control. While it is low, every incoming pause event is ignored and the output stays low. Dropping it during a pause releases the transmitter at once. The block does not parse frames and does not drive the transmitter. It only reports whether transmission is held.

Top module: `pause_quanta_timer`

## Requirements
- R1: After synchronous reset, `tx_paused` is low and the internal quanta count is zero.
- R2: An event (`evt_valid` high) with non-zero `evt_quanta` while `rx_resp_en` is high loads the count with `evt_quanta`, and `tx_paused` is high from the next cycle.
- R3: One quanta unit lasts exactly 64 `byte_tick` pulses. The count decrements once per 64 ticks. The tick prescaler is cleared by every XOFF load, so the first decrement comes on the 64th tick after the load.
- R4: `tx_paused` is high exactly while the count is non-zero and falls at the edge where the count reaches zero. With `byte_tick` high every cycle, a pause of Q quanta lasts Q*64 cycles.
- R5: An event with `evt_quanta` equal to zero while enabled clears the count, and `tx_paused` is low from the next cycle.
- R6: An XOFF that arrives during an active pause replaces the remaining count with its own quanta and does not add to it.
- R7: While `rx_resp_en` is low, events have no effect and `tx_paused` is low from the next cycle. Dropping the enable during a pause clears the count.
- R8: When an XOFF load and a `byte_tick` fall in the same cycle, the load wins and that tick is not counted toward the next slot.
- R9: Priority per cycle is, from highest to lowest: enable low, then event, then slot decrement. This ordering holds under arbitrary interleaving of events, enable changes and ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_resp_en | input | 1 | Honour received pause events when high |
| evt_valid | input | 1 | One-cycle pulse: a pause event is presented |
| evt_quanta | input | 16 | Pause time in slot units; zero means resume |
| byte_tick | input | 1 | One pulse per byte time on the line |
| tx_paused | output | 1 | High while the transmitter must hold off new frames |

## Verification
The hardest cases are the ones where an event, an enable change and the 64th prescaler tick all land on the same edge. Only the exact tick phase decides which rule takes effect there. Directed sequences measure the exact pause length for several quanta values, with dense and sparse tick patterns, and around reloads and cancels. A long random phase then drives rare events with small quanta, random ticks and occasional enable drops. This packs many collisions with the slot boundary into a few thousand cycles. A behavioural model checks each of them on every clock.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
  // Action applied to the quanta counter in one cycle
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_CLEAR = 2'd2,
    CMD_DEC   = 2'd3
  } cnt_cmd_e;
endpackage

// File: rtl/pqt_slot_prescaler.sv
module pqt_slot_prescaler #(
  parameter int SLOT_BYTES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic byte_tick,
  output logic slot_tick
);
  localparam int PRE_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(SLOT_BYTES - 1);

  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last   = (pre_q == LAST);
  assign slot_tick = byte_tick && !clr && at_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
    end else if (byte_tick) begin
      if (at_last) pre_q <= '0;
      else         pre_q <= pre_q + 1'b1;
    end
  end

  // R3
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0));

  // R8
  pre_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_tick && !clr && !at_last) |=> (pre_q == $past(pre_q) + 1'b1));

  // R3
  pre_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!byte_tick && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/pqt_evt_decode.sv
module pqt_evt_decode #(
  parameter int QW = 16
) (
  input  logic                  resp_en,
  input  logic                  evt_valid,
  input  logic [QW-1:0]         evt_quanta,
  input  logic                  slot_tick,
  output pqt_pkg::cnt_cmd_e     cmd,
  output logic                  pre_clr
);
  import pqt_pkg::*;

  logic is_xoff;
  assign is_xoff = evt_valid && (evt_quanta != '0);
  assign pre_clr = resp_en && is_xoff;

  always_comb begin
    if (!resp_en)        cmd = CMD_CLEAR;
    else if (is_xoff)    cmd = CMD_LOAD;
    else if (evt_valid)  cmd = CMD_CLEAR;
    else if (slot_tick)  cmd = CMD_DEC;
    else                 cmd = CMD_HOLD;
  end
endmodule

// File: rtl/pqt_quanta_counter.sv
module pqt_quanta_counter #(
  parameter int QW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pqt_pkg::cnt_cmd_e cmd,
  input  logic [QW-1:0]     load_val,
  output logic [QW-1:0]     cnt_nxt
);
  import pqt_pkg::*;

  logic [QW-1:0] cnt_q;

  always_comb begin
    unique case (cmd)
      CMD_LOAD:  cnt_nxt = load_val;
      CMD_CLEAR: cnt_nxt = '0;
      CMD_DEC:   cnt_nxt = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      default:   cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (cnt_q == $past(load_val)));

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLEAR) |=> (cnt_q == '0));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_DEC && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_HOLD || (cmd == CMD_DEC && cnt_q == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
  parameter int QUANTA_W   = 16,
  parameter int SLOT_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_resp_en,
  input  logic                evt_valid,
  input  logic [QUANTA_W-1:0] evt_quanta,
  input  logic                byte_tick,
  output logic                tx_paused
);
  import pqt_pkg::*;

  cnt_cmd_e            cmd;
  logic                pre_clr;
  logic                slot_tick;
  logic [QUANTA_W-1:0] cnt_nxt;
  logic                paused_q;

  pqt_slot_prescaler #(.SLOT_BYTES(SLOT_BYTES)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .clr       (pre_clr),
    .byte_tick (byte_tick),
    .slot_tick (slot_tick)
  );

  pqt_evt_decode #(.QW(QUANTA_W)) u_dec (
    .resp_en    (rx_resp_en),
    .evt_valid  (evt_valid),
    .evt_quanta (evt_quanta),
    .slot_tick  (slot_tick),
    .cmd        (cmd),
    .pre_clr    (pre_clr)
  );

  pqt_quanta_counter #(.QW(QUANTA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .load_val (evt_quanta),
    .cnt_nxt  (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) paused_q <= 1'b0;
    else     paused_q <= (cnt_nxt != '0);
  end

  assign tx_paused = paused_q;

  // R7
  dis_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_resp_en |=> !tx_paused);

  // R2
  xoff_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_resp_en && evt_valid && evt_quanta != '0) |=> tx_paused);

  // R5
  xon_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_resp_en && evt_valid && evt_quanta == '0) |=> !tx_paused);

  // R4
  no_spont_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_paused && !(rx_resp_en && evt_valid)) |=> !tx_paused);
endmodule

// File: tb/sim_pause_quanta_timer.sv
module sim_pause_quanta_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_resp_en = 1'b1;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_quanta = '0;
  logic        byte_tick = 1'b0;
  logic        tx_paused;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  string cur_req = "R1";

  // reference model state
  int ref_cnt = 0;
  int ref_pre = 0;
  bit ref_p   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  pause_quanta_timer u0 (
    .clk        (clk),
    .rst        (rst),
    .rx_resp_en (rx_resp_en),
    .evt_valid  (evt_valid),
    .evt_quanta (evt_quanta),
    .byte_tick  (byte_tick),
    .tx_paused  (tx_paused)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: applied at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      ref_cnt = 0; ref_pre = 0; ref_p = 1'b0;
    end else begin
      bit is_load;
      bit slot;
      is_load = rx_resp_en && evt_valid && (evt_quanta != 0);
      slot = byte_tick && !is_load && (ref_pre == 63);
      if (is_load)        ref_pre = 0;
      else if (byte_tick) ref_pre = (ref_pre + 1) % 64;
      if (!rx_resp_en)     ref_cnt = 0;
      else if (evt_valid)  ref_cnt = int'(evt_quanta);
      else if (slot && ref_cnt > 0) ref_cnt = ref_cnt - 1;
      ref_p = (ref_cnt != 0);
    end
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst) chk(tx_paused == ref_p, cur_req, int'(tx_paused), int'(ref_p));
  end

  task automatic drive(input bit en, input bit ev, input int q, input bit bt);
    @(negedge clk);
    rx_resp_en = en; evt_valid = ev; evt_quanta = 16'(q); byte_tick = bt;
  endtask

  // idle cycles; byte tick every 'per' cycles; returns cycles with pause high
  task automatic run(input int n, input int per, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_paused) hi++;
      evt_valid = 1'b0;
      byte_tick = ((i % per) == per - 1) || (per == 1);
    end
  endtask

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(tx_paused == 1'b0, "R1", int'(tx_paused), 0);
    rst = 1'b0;
    run(3, 1, hi);
    chk(hi == 0, "R1", hi, 0);

    // R2/R4: 3 quanta with a tick each cycle lasts 192 cycles
    cur_req = "R4";
    drive(1, 1, 3, 1);
    run(260, 1, hi);
    chk(hi == 192, "R4", hi, 192);

    // R8: load coincident with a tick, one quanta -> 64 cycles
    cur_req = "R8";
    run(17, 1, hi);
    drive(1, 1, 1, 1);
    run(100, 1, hi);
    chk(hi == 64, "R8", hi, 64);

    // R3: sparse ticks (every 2nd cycle), 2 quanta -> 256 cycles
    cur_req = "R3";
    run(9, 1, hi);
    drive(1, 1, 2, 0);
    run(320, 2, hi);
    chk(hi == 256, "R3", hi, 256);

    // R2: pause visible on the cycle after the load
    cur_req = "R2";
    drive(1, 1, 9, 0);
    @(negedge clk);
    chk(tx_paused == 1'b1, "R2", int'(tx_paused), 1);
    evt_valid = 1'b0;

    // R6: reload mid-pause replaces the count
    cur_req = "R6";
    drive(1, 1, 5, 1);
    run(100, 1, hi);
    drive(1, 1, 2, 1);
    run(200, 1, hi);
    chk(hi == 128, "R6", hi, 128);

    // R5: XON cancels at once
    cur_req = "R5";
    drive(1, 1, 4, 1);
    run(50, 1, hi);
    drive(1, 1, 0, 1);
    @(negedge clk);
    chk(tx_paused == 1'b0, "R5", int'(tx_paused), 0);
    run(300, 1, hi);
    chk(hi == 0, "R5", hi, 0);

    // R7: disabled events are ignored; drop during pause releases
    cur_req = "R7";
    drive(0, 1, 7, 1);
    run(10, 1, hi);
    chk(hi == 0, "R7", hi, 0);
    drive(1, 1, 7, 1);
    run(20, 1, hi);
    chk(hi == 20, "R7", hi, 20);
    drive(0, 0, 0, 1);
    @(negedge clk);
    chk(tx_paused == 1'b0, "R7", int'(tx_paused), 0);
    rx_resp_en = 1'b1;
    run(300, 1, hi);
    chk(hi == 0, "R7", hi, 0);

    // R9: random interleaving checked against the model every cycle
    cur_req = "R9";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      rx_resp_en = ($urandom_range(0, 99) != 0);
      evt_valid  = ($urandom_range(0, 39) == 0);
      evt_quanta = 16'($urandom_range(0, 3));
      byte_tick  = $urandom_range(0, 1) == 1;
    end
    run(5, 1, hi);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule